// File: doc/BRIEF.md
# Up/Down Reload Timer with Double-Buffered Update

This block is a 16-bit timer that advances once for every cycle in which its tick enable is high. It counts upward or downward. When it runs past its end value, it does not roll over. Instead it loads a start value from an active reload register. Each such wrap sets a sticky overflow flag. The flag drives an interrupt request, gated by a global enable and a local enable.

The reload register and three compare registers (A, B, C) are double-buffered. Software writes bytes into shadow copies. It then writes a 1 to a single update bit to move all four shadow words into the active registers at once. In basic mode the move happens in that same cycle. In PWM mode the move waits for the next wrap. While the move is waiting, the update bit reads back as 1, so software can see when the new values have taken effect.

Top module: `updn_reload_timer`

## Requirements
- R1: Counting up (direction input 0) from 0xFFFF, a tick loads the count from the active reload register instead of going to zero.
- R2: Counting down (direction input 1) from 0x0000, a tick loads the count from the active reload register.
- R3: On a tick that is not a wrap, the count moves by exactly one in the selected direction. Without a tick, the count holds.
- R4: The overflow flag becomes 1 at the same clock edge at which the wrap reload takes place.
- R5: The overflow flag stays 1 until a write to select code 9 with data bit 0 equal to 0. A write of 1 there has no effect. A wrap in the same cycle as a clear leaves the flag set.
- R6: The interrupt output is 1 exactly when the overflow flag, the global enable and the local enable are all 1.
- R7: A write to select codes 0 to 7 changes only a shadow byte. The codes are: 0/1 reload low/high, 2/3 compare A low/high, 4/5 compare B low/high, 6/7 compare C low/high. The active registers keep their value until an update.
- R8: In basic mode (mode input 0), a write to select code 8 with data bit 0 equal to 1 copies all shadow words into the active registers at that edge. The update bit reads 0.
- R9: In PWM mode (mode input 1), the same write sets the update bit to 1. At the next wrap, the shadows are copied into the active registers and the update bit returns to 0. The counter reloads from the value that was active before that edge.
- R10: A further update request while a PWM transfer is pending has no extra effect. The shadow contents present at the wrap are the ones that are transferred.
- R11: The three compare registers move together with the reload register on every transfer.
- R12: After reset, the count, the active registers, the shadows, the update bit, the flag and the interrupt are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| tickEn | input | 1 | Timer advance enable |
| cntDown | input | 1 | Direction: 0 up, 1 down |
| pwmMode | input | 1 | Update timing: 0 immediate, 1 at next wrap |
| glbIrqEn | input | 1 | Global interrupt enable |
| locIrqEn | input | 1 | Timer interrupt enable |
| wrEn | input | 1 | Register write strobe |
| wrSel | input | 4 | Write target select code |
| wrData | input | 8 | Write data byte |
| count | output | 16 | Current timer value |
| reloadVal | output | 16 | Active reload value |
| cmpA | output | 16 | Active compare A |
| cmpB | output | 16 | Active compare B |
| cmpC | output | 16 | Active compare C |
| updBit | output | 1 | Update bit read-back (transfer pending) |
| ovfFlag | output | 1 | Sticky overflow flag |
| irq | output | 1 | Gated interrupt request |

## Verification
The bench goes after the edge cases where the active and shadow copies can be confused:
- An update request that arrives while a transfer is already pending. A design that restarts or cancels the pending state here would clear the update bit early or transfer too soon.
- A shadow byte that is rewritten after the request. A design that latched the shadows at request time would transfer stale values.
- The wrap edge itself. A design that reloaded from the freshly transferred value, or set the flag one cycle late, shows the wrong count or a flag that is still low.

Random write, tick and mode traffic is then compared, every cycle, against a bench model of the shadow and active copies. This exposes a clear that wins over a wrap, or a compare register left out of a transfer.

// File: rtl/updn_timer_pkg.sv
package updn_timer_pkg;
  localparam int CNT_W     = 16;
  localparam int BYTE_W    = 8;
  localparam int NUM_REG   = 4;                   // reload + three compares
  localparam int BYTES_PER = CNT_W / BYTE_W;
  localparam int NUM_SHB   = NUM_REG * BYTES_PER; // shadow bytes
  localparam int SEL_W     = 4;
  localparam int SEL_UPD   = NUM_SHB;             // update request code
  localparam int SEL_FLAG  = NUM_SHB + 1;         // flag register code

  typedef struct packed {
    logic               xfer;    // copy shadows into active registers
    logic [NUM_SHB-1:0] byteWr;  // per shadow byte write strobe
  } tmrStrobe_t;
endpackage

// File: rtl/timer_datapath.sv
module timer_datapath
  import updn_timer_pkg::*;
(
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     tickEn,
  input  logic                     cntDown,
  input  tmrStrobe_t               strobe,
  input  logic [BYTE_W-1:0]        wrData,
  output logic                     wrapHit,
  output logic [CNT_W-1:0]         count,
  output logic [NUM_REG*CNT_W-1:0] activeFlat
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_MIN = '0;

  logic [BYTE_W-1:0] shadowB   [NUM_SHB];
  logic [CNT_W-1:0]  shadowWord[NUM_REG];
  logic [CNT_W-1:0]  activeReg [NUM_REG];

  for (genvar b = 0; b < NUM_SHB; b++) begin : g_shadow
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)              shadowB[b] <= '0;
      else if (strobe.byteWr[b]) shadowB[b] <= wrData;
    end
  end

  for (genvar r = 0; r < NUM_REG; r++) begin : g_active
    for (genvar k = 0; k < BYTES_PER; k++) begin : g_word
      assign shadowWord[r][k*BYTE_W +: BYTE_W] = shadowB[r*BYTES_PER + k];
    end
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)            activeReg[r] <= '0;
      else if (strobe.xfer) activeReg[r] <= shadowWord[r];
    end
    assign activeFlat[r*CNT_W +: CNT_W] = activeReg[r];
  end

  assign wrapHit = tickEn && (cntDown ? (count == CNT_MIN) : (count == CNT_MAX));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        count <= '0;
    else if (wrapHit) count <= activeReg[0];
    else if (tickEn)  count <= cntDown ? count - 1'b1 : count + 1'b1;
  end

  AST_WRAP_RELOAD: assert property (@(posedge clk) disable iff (!rstN)
    wrapHit |=> count == $past(activeReg[0]));                      // R1
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !tickEn |=> $stable(count));                                    // R3
  AST_ACTIVE_KEEP: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.xfer |=> $stable(activeFlat));                          // R7
  AST_XFER_COPY: assert property (@(posedge clk) disable iff (!rstN)
    strobe.xfer |=> activeReg[0] == $past(shadowWord[0]));          // R8
  AST_CMP_COPY: assert property (@(posedge clk) disable iff (!rstN)
    strobe.xfer |=> activeReg[NUM_REG-1] == $past(shadowWord[NUM_REG-1])); // R11
endmodule

// File: rtl/timer_ctrl.sv
module timer_ctrl
  import updn_timer_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [SEL_W-1:0] wrSel,
  input  logic             wrBit0,
  input  logic             pwmMode,
  input  logic             wrapHit,
  input  logic             glbIrqEn,
  input  logic             locIrqEn,
  output tmrStrobe_t       strobe,
  output logic             updBit,
  output logic             ovfFlag,
  output logic             irq
);
  logic pending;
  logic updReq;
  logic flagClr;

  assign updReq  = wrEn && (wrSel == SEL_W'(SEL_UPD)) && wrBit0;
  assign flagClr = wrEn && (wrSel == SEL_W'(SEL_FLAG)) && !wrBit0;

  for (genvar i = 0; i < NUM_SHB; i++) begin : g_bytewr
    assign strobe.byteWr[i] = wrEn && (wrSel == SEL_W'(i));
  end
  assign strobe.xfer = (updReq && !pwmMode) || (wrapHit && pending);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                   pending <= 1'b0;
    else if (wrapHit && pending) pending <= 1'b0;
    else if (updReq && pwmMode)  pending <= 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        ovfFlag <= 1'b0;
    else if (wrapHit) ovfFlag <= 1'b1;
    else if (flagClr) ovfFlag <= 1'b0;
  end

  assign updBit = pending;
  assign irq    = ovfFlag && glbIrqEn && locIrqEn;

  AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rstN)
    wrapHit |=> ovfFlag);                                           // R4
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (ovfFlag && !flagClr) |=> ovfFlag);                             // R5
  AST_PEND_DONE: assert property (@(posedge clk) disable iff (!rstN)
    (pending && wrapHit) |=> !updBit);                              // R9
  AST_BASIC_NO_PEND: assert property (@(posedge clk) disable iff (!rstN)
    (!pwmMode && !pending) |=> !updBit);                            // R8
  AST_PEND_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (pending && !wrapHit) |=> updBit);                              // R10
endmodule

// File: rtl/updn_reload_timer.sv
module updn_reload_timer
  import updn_timer_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic              cntDown,
  input  logic              pwmMode,
  input  logic              glbIrqEn,
  input  logic              locIrqEn,
  input  logic              wrEn,
  input  logic [SEL_W-1:0]  wrSel,
  input  logic [BYTE_W-1:0] wrData,
  output logic [CNT_W-1:0]  count,
  output logic [CNT_W-1:0]  reloadVal,
  output logic [CNT_W-1:0]  cmpA,
  output logic [CNT_W-1:0]  cmpB,
  output logic [CNT_W-1:0]  cmpC,
  output logic              updBit,
  output logic              ovfFlag,
  output logic              irq
);
  tmrStrobe_t               strobe;
  logic                     wrapHit;
  logic [NUM_REG*CNT_W-1:0] activeFlat;

  timer_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrBit0(wrData[0]),
    .pwmMode(pwmMode), .wrapHit(wrapHit), .glbIrqEn(glbIrqEn),
    .locIrqEn(locIrqEn), .strobe(strobe), .updBit(updBit),
    .ovfFlag(ovfFlag), .irq(irq)
  );

  timer_datapath u_dp (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .cntDown(cntDown),
    .strobe(strobe), .wrData(wrData), .wrapHit(wrapHit), .count(count),
    .activeFlat(activeFlat)
  );

  assign reloadVal = activeFlat[0*CNT_W +: CNT_W];
  assign cmpA      = activeFlat[1*CNT_W +: CNT_W];
  assign cmpB      = activeFlat[2*CNT_W +: CNT_W];
  assign cmpC      = activeFlat[3*CNT_W +: CNT_W];
endmodule

// File: tb/sim_updn_reload_timer.sv
module sim_updn_reload_timer;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tickEn = 0, cntDown = 0, pwmMode = 0, glbIrqEn = 0, locIrqEn = 0;
  logic wrEn = 0;
  logic [3:0] wrSel = '0;
  logic [7:0] wrData = '0;
  logic [15:0] count, reloadVal, cmpA, cmpB, cmpC;
  logic updBit, ovfFlag, irq;

  int total = 0;
  int bad = 0;

  logic [15:0] mCount;
  logic [15:0] mAct[4];
  logic [7:0]  mSh[8];
  logic        mPend, mFlag;

  always #5 clk = ~clk;

  updn_reload_timer u0 (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .cntDown(cntDown),
    .pwmMode(pwmMode), .glbIrqEn(glbIrqEn), .locIrqEn(locIrqEn),
    .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData), .count(count),
    .reloadVal(reloadVal), .cmpA(cmpA), .cmpB(cmpB), .cmpC(cmpC),
    .updBit(updBit), .ovfFlag(ovfFlag), .irq(irq)
  );

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] nextCount(logic [15:0] c, logic tk, logic dn,
                                            logic [15:0] rl);
    logic w;
    w = tk && (dn ? (c == 16'h0000) : (c == 16'hFFFF));
    if (!tk) return c;
    if (w)   return rl;
    return dn ? c - 16'd1 : c + 16'd1;
  endfunction

  task automatic modelStep();
    logic w, upd, xf, clr;
    w   = tickEn && (cntDown ? (mCount == 16'h0000) : (mCount == 16'hFFFF));
    upd = wrEn && wrSel == 4'd8 && wrData[0];
    clr = wrEn && wrSel == 4'd9 && !wrData[0];
    xf  = (upd && !pwmMode) || (w && mPend);
    mCount = nextCount(mCount, tickEn, cntDown, mAct[0]);
    if (xf) for (int r = 0; r < 4; r++) mAct[r] = {mSh[2*r+1], mSh[2*r]};
    if (w && mPend)          mPend = 1'b0;
    else if (upd && pwmMode) mPend = 1'b1;
    if (w)        mFlag = 1'b1;
    else if (clr) mFlag = 1'b0;
    if (wrEn && wrSel < 4'd8) mSh[wrSel[2:0]] = wrData;
  endtask

  task automatic compareAll();
    chk("R3", "count", {16'h0, count}, {16'h0, mCount});
    chk("R8", "reload", {16'h0, reloadVal}, {16'h0, mAct[0]});
    chk("R11", "cmpA", {16'h0, cmpA}, {16'h0, mAct[1]});
    chk("R11", "cmpB", {16'h0, cmpB}, {16'h0, mAct[2]});
    chk("R11", "cmpC", {16'h0, cmpC}, {16'h0, mAct[3]});
    chk("R9", "updBit", {31'h0, updBit}, {31'h0, mPend});
    chk("R5", "flag", {31'h0, ovfFlag}, {31'h0, mFlag});
    chk("R6", "irq", {31'h0, irq}, {31'h0, mFlag & glbIrqEn & locIrqEn});
  endtask

  // drive inputs for one clock, advance model, then check after the edge
  task automatic cyc(logic tk, logic we, logic [3:0] sel, logic [7:0] d);
    tickEn = tk; wrEn = we; wrSel = sel; wrData = d;
    modelStep();
    @(negedge clk);
    tickEn = 0; wrEn = 0;
    #1;
    compareAll();
  endtask

  initial begin
    for (int r = 0; r < 4; r++) mAct[r] = '0;
    for (int b = 0; b < 8; b++) mSh[b] = '0;
    mCount = '0; mPend = 0; mFlag = 0;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    // R12 reset state
    chk("R12", "count", {16'h0, count}, 32'h0);
    chk("R12", "reload", {16'h0, reloadVal}, 32'h0);
    chk("R12", "cmpA", {16'h0, cmpA}, 32'h0);
    chk("R12", "flags", {29'h0, updBit, ovfFlag, irq}, 32'h0);

    // R7 shadow writes leave active untouched
    cyc(0, 1, 4'd0, 8'hF0);
    cyc(0, 1, 4'd1, 8'hFF);
    chk("R7", "reload after shadow write", {16'h0, reloadVal}, 32'h0);
    // R8 immediate update in basic mode
    cyc(0, 1, 4'd8, 8'h01);
    chk("R8", "reload after basic update", {16'h0, reloadVal}, 32'hFFF0);
    chk("R8", "updBit basic", {31'h0, updBit}, 32'h0);
    // R2 down wrap from zero, R4 flag set on same edge
    cntDown = 1;
    cyc(1, 0, 4'd0, 8'h00);
    chk("R2", "count after down wrap", {16'h0, count}, 32'hFFF0);
    chk("R4", "flag after wrap", {31'h0, ovfFlag}, 32'h1);
    // R6 gating
    glbIrqEn = 1; locIrqEn = 0; #1;
    chk("R6", "irq local off", {31'h0, irq}, 32'h0);
    locIrqEn = 1; #1;
    chk("R6", "irq both on", {31'h0, irq}, 32'h1);
    // R5 write 1 ignored, write 0 clears
    cyc(0, 1, 4'd9, 8'h01);
    chk("R5", "flag after write 1", {31'h0, ovfFlag}, 32'h1);
    cyc(0, 1, 4'd9, 8'h00);
    chk("R5", "flag after write 0", {31'h0, ovfFlag}, 32'h0);
    // R9/R10/R11 pending transfer in PWM mode
    cntDown = 0; pwmMode = 1;
    cyc(0, 1, 4'd0, 8'h00);
    cyc(0, 1, 4'd2, 8'hAA);
    cyc(0, 1, 4'd3, 8'hAA);
    cyc(0, 1, 4'd8, 8'h01);
    chk("R9", "updBit pending", {31'h0, updBit}, 32'h1);
    chk("R9", "reload held while pending", {16'h0, reloadVal}, 32'hFFF0);
    cyc(0, 1, 4'd0, 8'h80);
    cyc(0, 1, 4'd8, 8'h01);
    chk("R10", "updBit after second request", {31'h0, updBit}, 32'h1);
    for (int i = 0; i < 15; i++) cyc(1, 0, 4'd0, 8'h00);
    chk("R3", "count before up wrap", {16'h0, count}, 32'hFFFF);
    chk("R9", "still pending", {31'h0, updBit}, 32'h1);
    cyc(1, 0, 4'd0, 8'h00);
    chk("R1", "count after up wrap", {16'h0, count}, 32'hFFF0);
    chk("R10", "reload takes shadow at wrap", {16'h0, reloadVal}, 32'hFF80);
    chk("R11", "cmpA moved with reload", {16'h0, cmpA}, 32'hAAAA);
    chk("R9", "updBit cleared", {31'h0, updBit}, 32'h0);
    chk("R4", "flag at pwm wrap", {31'h0, ovfFlag}, 32'h1);

    // constrained random traffic
    for (int n = 0; n < 4000; n++) begin
      logic [3:0] sel;
      logic [7:0] d;
      if ((n % 64) == 0) begin
        cntDown = 1'($urandom);
        pwmMode = 1'($urandom);
      end
      glbIrqEn = 1'($urandom);
      locIrqEn = 1'($urandom);
      sel = 4'($urandom_range(0, 9));
      d = 8'($urandom);
      if (sel == 4'd1) d = ($urandom_range(0, 1) == 1) ? 8'hFF : 8'h00;
      if (sel == 4'd9) d = {7'h0, 1'($urandom)};
      cyc(($urandom_range(0, 3) != 0), ($urandom_range(0, 3) == 0), sel, d);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1000000;
    total++;
    bad++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule